// File: doc/BRIEF.md
# Real-Time Time-Base Counter with Alarm

This block keeps a 32-bit running time count. It takes one of several slow pulse sources and divides it with a reloadable 20-bit prescaler. Each time the prescaler runs out it produces one time-base tick. On that tick the count advances by one and a periodic flag is set. If the count that results equals a programmable 32-bit compare value, an alarm flag is set. If the count wraps from all ones to zero, an overflow flag is set. Each flag drives its own interrupt through its own enable bit.

All logic runs on the system clock. The slow sources arrive as one-cycle enable strobes: an external 32.768 kHz strobe and an internal RC strobe of about 40 kHz. The third source is made inside the block by dividing the system clock by 128. A separate square-wave output runs at one sixty-fourth of the external strobe rate, which is 512 Hz from a 32.768 kHz input. This output serves for trimming.

Software reaches the block through a simple register port. Writes take effect on the next clock edge. Reads are combinational. The prescaler reload, count and compare registers can only be written while a configuration bit is set. Time stands still while that bit is set.

Top module: `rtc_timebase`

## Requirements
- R1: After reset the reload register reads 32767, the count reads 0, the compare register reads 0xFFFFFFFF, and the control and status registers read 0.
- R2: With a reload value N in the reload register (address 2, bits 19:0), a time-base tick occurs once every N+1 pulses of the selected source.
- R3: The count register (address 3) advances by exactly one on each tick and does not change otherwise, unless it is written.
- R4: Every tick sets the periodic flag (status bit 0). irq_tick_o is high while that flag and the tick enable (control bit 2) are both set.
- R5: A tick that makes the count equal to the compare register (address 4) sets the alarm flag (status bit 1). irq_alarm_o is high while that flag and the alarm enable (control bit 1) are both set.
- R6: Control bits 5:4 pick the source. The codes are 0 for the external strobe, 1 for the RC strobe, 2 for the system clock divided by 128, and 3 for no source, in which case the count is frozen.
- R7: cal_o toggles once for every 32 external strobes, whatever source is selected, so its period is 64 external strobes.
- R8: Writes to reload, count and compare are ignored unless the configuration bit (control bit 0) is set. While that bit is set no tick occurs. When the bit is cleared, the prescaler starts again from the full reload value.
- R9: Status flags stay set until software writes a one to their bit at address 1. If a flag is set and cleared in the same cycle, the set wins.
- R10: A tick taken at count 0xFFFFFFFF wraps the count to 0 and sets the overflow flag (status bit 2). irq_ovf_o is high while that flag and the overflow enable (control bit 3) are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_pulse_i | input | 1 | One-cycle strobe from the external 32.768 kHz source |
| rc_pulse_i | input | 1 | One-cycle strobe from the internal RC source |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 32 | Register read data (combinational) |
| irq_tick_o | output | 1 | Periodic interrupt |
| irq_alarm_o | output | 1 | Alarm interrupt |
| irq_ovf_o | output | 1 | Overflow interrupt |
| cal_o | output | 1 | Calibration square wave |

## Verification
The bench goes after the first tick under the default reload. Counting 32767 pulses instead of 32768 there shows an off-by-one prescaler. It drives an alarm match on a small reload, and a wrap from 0xFFFFFFFD through zero. A design that compares the old count, or misses the wrap, would flag the alarm one tick late or leave the overflow flag clear. It writes to locked registers outside configuration mode and leaves configuration mode part-way through a prescale. Letting a locked write through, or resuming from a stale prescaler value, would throw off every later tick. It also switches among all four source codes and clears one flag while leaving the others set. The behavioural model, compared on every clock, catches a wrong source mapping or a clear that reaches the wrong flag.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    parameter int PRE_W      = 20;
    parameter int CNT_W      = 32;
    parameter int RELOAD_RST = 32767;
    parameter int HS_DIV     = 128;
    parameter int CAL_DIV    = 64;

    localparam logic [2:0] A_CTRL   = 3'd0;
    localparam logic [2:0] A_STAT   = 3'd1;
    localparam logic [2:0] A_RELOAD = 3'd2;
    localparam logic [2:0] A_COUNT  = 3'd3;
    localparam logic [2:0] A_CMP    = 3'd4;

    typedef enum logic [1:0] {
        SRC_EXT  = 2'd0,
        SRC_RC   = 2'd1,
        SRC_HS   = 2'd2,
        SRC_NONE = 2'd3
    } src_e;

    typedef struct packed {
        logic             cfg;
        logic             ie_alarm;
        logic             ie_tick;
        logic             ie_ovf;
        src_e             sel;
        logic [PRE_W-1:0] reload;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cmp;
        logic             f_tick;
        logic             f_alarm;
        logic             f_ovf;
    } state_t;
endpackage

// File: rtl/rtc_src_sel.sv
module rtc_src_sel
    import rtc_pkg::*;
#(
    parameter int DIV = HS_DIV
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  src_e sel_i,
    input  logic ext_i,
    input  logic rc_i,
    output logic pulse_o
);
    localparam int W = $clog2(DIV);
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] hs_d, hs_q;
    logic         hs_pulse;

    always_comb begin
        hs_pulse = (hs_q == LAST);
        hs_d     = hs_pulse ? '0 : hs_q + 1'b1;
        case (sel_i)
            SRC_EXT: pulse_o = ext_i;
            SRC_RC:  pulse_o = rc_i;
            SRC_HS:  pulse_o = hs_pulse;
            default: pulse_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hs_q <= '0;
        else         hs_q <= hs_d;
    end

    // R6
    hs_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hs_pulse |=> !hs_pulse);
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
    import rtc_pkg::*;
#(
    parameter int W = PRE_W
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         src_i,
    input  logic         run_i,
    input  logic         restart_i,
    input  logic [W-1:0] reload_i,
    output logic         tick_o
);
    logic [W-1:0] div_d, div_q;

    always_comb begin
        tick_o = run_i && src_i && (div_q == '0);
        div_d  = div_q;
        if (restart_i)               div_d = reload_i;
        else if (run_i && src_i)     div_d = (div_q == '0) ? reload_i : div_q - 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) div_q <= W'(RELOAD_RST);
        else         div_q <= div_d;
    end

    // R8
    restart_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |=> div_q == $past(reload_i));
    // R8
    halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_i && !restart_i) |=> $stable(div_q));
endmodule

// File: rtl/rtc_cal_div.sv
module rtc_cal_div
    import rtc_pkg::*;
#(
    parameter int DIV = CAL_DIV
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ext_i,
    output logic cal_o
);
    localparam int HALF = DIV / 2;
    localparam int W    = $clog2(HALF);
    localparam logic [W-1:0] LAST = W'(HALF - 1);

    logic [W-1:0] cnt_d, cnt_q;
    logic         cal_d, cal_q;

    always_comb begin
        cnt_d = cnt_q;
        cal_d = cal_q;
        if (ext_i) begin
            if (cnt_q == LAST) begin
                cnt_d = '0;
                cal_d = !cal_q;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            cal_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            cal_q <= cal_d;
        end
    end

    assign cal_o = cal_q;

    // R7
    cal_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ext_i |=> $stable(cal_o));
endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase
    import rtc_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        ext_pulse_i,
    input  logic        rc_pulse_i,
    input  logic        wr_en_i,
    input  logic [2:0]  wr_addr_i,
    input  logic [31:0] wr_data_i,
    input  logic [2:0]  rd_addr_i,
    output logic [31:0] rd_data_o,
    output logic        irq_tick_o,
    output logic        irq_alarm_o,
    output logic        irq_ovf_o,
    output logic        cal_o
);
    state_t           st_d, st_q;
    logic             src_pulse, tick, cfg_next, cnt_wr, clr_wr;
    logic [CNT_W-1:0] cnt_inc;

    assign cfg_next = (wr_en_i && wr_addr_i == A_CTRL) ? wr_data_i[0] : st_q.cfg;
    assign cnt_wr   = st_q.cfg && wr_en_i && wr_addr_i == A_COUNT;
    assign clr_wr   = wr_en_i && wr_addr_i == A_STAT;
    assign cnt_inc  = st_q.cnt + 1'b1;

    rtc_src_sel #(.DIV(HS_DIV)) src_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(st_q.sel),
        .ext_i(ext_pulse_i), .rc_i(rc_pulse_i), .pulse_o(src_pulse));

    rtc_prescaler #(.W(PRE_W)) pre_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_pulse),
        .run_i(!st_q.cfg), .restart_i(st_q.cfg && !cfg_next),
        .reload_i(st_q.reload), .tick_o(tick));

    rtc_cal_div #(.DIV(CAL_DIV)) cal_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .ext_i(ext_pulse_i), .cal_o(cal_o));

    always_comb begin
        st_d     = st_q;
        st_d.cfg = cfg_next;
        if (wr_en_i && wr_addr_i == A_CTRL) begin
            st_d.ie_alarm = wr_data_i[1];
            st_d.ie_tick  = wr_data_i[2];
            st_d.ie_ovf   = wr_data_i[3];
            st_d.sel      = src_e'(wr_data_i[5:4]);
        end
        if (st_q.cfg && wr_en_i && wr_addr_i == A_RELOAD) st_d.reload = wr_data_i[PRE_W-1:0];
        if (st_q.cfg && wr_en_i && wr_addr_i == A_CMP)    st_d.cmp    = wr_data_i[CNT_W-1:0];
        if (cnt_wr)    st_d.cnt = wr_data_i[CNT_W-1:0];
        else if (tick) st_d.cnt = cnt_inc;
        if (clr_wr) begin
            if (wr_data_i[0]) st_d.f_tick  = 1'b0;
            if (wr_data_i[1]) st_d.f_alarm = 1'b0;
            if (wr_data_i[2]) st_d.f_ovf   = 1'b0;
        end
        if (tick)                       st_d.f_tick  = 1'b1;
        if (tick && cnt_inc == st_q.cmp) st_d.f_alarm = 1'b1;
        if (tick && &st_q.cnt)          st_d.f_ovf   = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q        <= '0;
            st_q.sel    <= SRC_EXT;
            st_q.reload <= PRE_W'(RELOAD_RST);
            st_q.cmp    <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            A_CTRL:   rd_data_o[5:0] = {st_q.sel, st_q.ie_ovf, st_q.ie_tick,
                                        st_q.ie_alarm, st_q.cfg};
            A_STAT:   rd_data_o[2:0] = {st_q.f_ovf, st_q.f_alarm, st_q.f_tick};
            A_RELOAD: rd_data_o[PRE_W-1:0] = st_q.reload;
            A_COUNT:  rd_data_o[CNT_W-1:0] = st_q.cnt;
            A_CMP:    rd_data_o[CNT_W-1:0] = st_q.cmp;
            default:  rd_data_o = '0;
        endcase
    end

    assign irq_tick_o  = st_q.f_tick  && st_q.ie_tick;
    assign irq_alarm_o = st_q.f_alarm && st_q.ie_alarm;
    assign irq_ovf_o   = st_q.f_ovf   && st_q.ie_ovf;

    // R3
    count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick && !cnt_wr) |=> st_q.cnt == $past(st_q.cnt) + 1'b1);
    // R8
    cfg_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cfg |-> !tick);
    // R5
    alarm_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick && cnt_inc == st_q.cmp) |=> st_q.f_alarm);
    // R9
    alarm_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.f_alarm && !(clr_wr && wr_data_i[1])) |=> st_q.f_alarm);
    // R10
    wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick && &st_q.cnt && !cnt_wr) |=> (st_q.cnt == '0 && st_q.f_ovf));
endmodule

// File: tb/rtc_timebase_tb.sv
module rtc_timebase_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_pulse = 1'b0, rc_pulse = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq_tick, irq_alarm, irq_ovf, cal;

    int checks = 0, errors = 0, cyc_n = 0, ext_every = 1;
    bit hold_rd = 1'b0, done = 1'b0;

    rtc_timebase dut_i (
        .clk_i(clk), .rst_ni(rst_n), .ext_pulse_i(ext_pulse), .rc_pulse_i(rc_pulse),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .irq_tick_o(irq_tick), .irq_alarm_o(irq_alarm), .irq_ovf_o(irq_ovf), .cal_o(cal));

    always #(CLK_PERIOD/2) clk = !clk;

    // behavioural reference state
    bit          m_cfg, m_iea, m_iet, m_ieo, m_ft, m_fa, m_fo, m_cal;
    int          m_sel, m_reload, m_div, m_hs, m_calc;
    logic [31:0] m_cnt, m_cmp;

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return 32'(m_sel * 16 + m_ieo * 8 + m_iet * 4 + m_iea * 2 + m_cfg);
            3'd1: return 32'(m_fo * 4 + m_fa * 2 + m_ft);
            3'd2: return 32'(m_reload);
            3'd3: return m_cnt;
            3'd4: return m_cmp;
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg = 0; m_iea = 0; m_iet = 0; m_ieo = 0; m_ft = 0; m_fa = 0; m_fo = 0;
            m_cal = 0; m_sel = 0; m_reload = 32767; m_div = 32767; m_hs = 0; m_calc = 0;
            m_cnt = 0; m_cmp = 32'hFFFF_FFFF;
        end else begin
            bit src, tick, ncfg;
            logic [31:0] old;
            case (m_sel)
                0: src = ext_pulse;
                1: src = rc_pulse;
                2: src = (m_hs == 127);
                default: src = 0;
            endcase
            tick = !m_cfg && src && m_div == 0;
            ncfg = (wr_en && wr_addr == 0) ? wr_data[0] : m_cfg;
            if (m_cfg && !ncfg) m_div = m_reload;
            else if (!m_cfg && src) m_div = (m_div == 0) ? m_reload : m_div - 1;
            m_hs = (m_hs + 1) % 128;
            if (ext_pulse) begin
                if (m_calc == 31) begin m_calc = 0; m_cal = !m_cal; end
                else m_calc++;
            end
            old = m_cnt;
            if (m_cfg && wr_en && wr_addr == 3) m_cnt = wr_data;
            else if (tick) m_cnt = old + 32'd1;
            if (wr_en && wr_addr == 1) begin
                if (wr_data[0]) m_ft = 0;
                if (wr_data[1]) m_fa = 0;
                if (wr_data[2]) m_fo = 0;
            end
            if (tick) m_ft = 1;
            if (tick && old + 32'd1 == m_cmp) m_fa = 1;
            if (tick && old == 32'hFFFF_FFFF) m_fo = 1;
            if (m_cfg && wr_en && wr_addr == 2) m_reload = int'(wr_data[19:0]);
            if (m_cfg && wr_en && wr_addr == 4) m_cmp = wr_data;
            if (wr_en && wr_addr == 0) begin
                m_iea = wr_data[1]; m_iet = wr_data[2]; m_ieo = wr_data[3];
                m_sel = int'(wr_data[5:4]);
            end
            m_cfg = ncfg;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic string reg_req(input logic [2:0] a);
        case (a)
            3'd0: return "R6";
            3'd1: return "R9";
            3'd2: return "R2";
            3'd3: return "R3";
            3'd4: return "R5";
            default: return "R1";
        endcase
    endfunction

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(rd_data == m_read(rd_addr), reg_req(rd_addr), rd_data, m_read(rd_addr));
            chk(irq_tick == (m_ft && m_iet), "R4", 32'(irq_tick), 32'(m_ft && m_iet));
            chk(irq_alarm == (m_fa && m_iea), "R5", 32'(irq_alarm), 32'(m_fa && m_iea));
            chk(irq_ovf == (m_fo && m_ieo), "R10", 32'(irq_ovf), 32'(m_fo && m_ieo));
            chk(cal == m_cal, "R7", 32'(cal), 32'(m_cal));
        end
    end

    // source strobes and rotating read address
    always @(posedge clk) begin
        #1;
        cyc_n++;
        ext_pulse = (ext_every != 0) && (cyc_n % ext_every == 0);
        rc_pulse  = (cyc_n % 3 == 0);
        if (!hold_rd) rd_addr = 3'(cyc_n % 5);
    end

    task automatic run(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(posedge clk); #2;
        hold_rd = 1'b1; rd_addr = a;
        #1 v = rd_data;
        @(negedge clk);
        hold_rd = 1'b0;
    endtask

    task automatic expect_reg(input logic [2:0] a, input logic [31:0] exp, input logic [31:0] mask, input string req);
        logic [31:0] v;
        rd(a, v);
        chk((v & mask) == (exp & mask), req, v & mask, exp & mask);
    endtask

    initial begin
        #(WATCHDOG * CLK_PERIOD);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] a, b;
        run(3); #1 rst_n = 1'b1;
        // R1 reset values
        expect_reg(3'd2, 32'd32767, '1, "R1");
        expect_reg(3'd3, 32'd0, '1, "R1");
        expect_reg(3'd4, 32'hFFFF_FFFF, '1, "R1");
        expect_reg(3'd1, 32'd0, '1, "R1");
        expect_reg(3'd0, 32'd0, '1, "R1");
        // R8 locked writes outside configuration mode
        wr(3'd3, 32'd55);
        wr(3'd4, 32'd9);
        expect_reg(3'd3, 32'd0, '1, "R8");
        expect_reg(3'd4, 32'hFFFF_FFFF, '1, "R8");
        // R2 default reload: first tick after 32768 strobes
        run(32800);
        expect_reg(3'd3, 32'd1, '1, "R2");
        expect_reg(3'd1, 32'd1, 32'd1, "R4");
        // R5 alarm on small reload, R8 restart on exit
        wr(3'd0, 32'h1);
        wr(3'd2, 32'd3);
        wr(3'd3, 32'd0);
        wr(3'd4, 32'd5);
        wr(3'd1, 32'h7);
        wr(3'd0, 32'hE);
        run(40);
        expect_reg(3'd1, 32'h2, 32'h2, "R5");
        chk(irq_alarm == 1'b1, "R5", 32'(irq_alarm), 32'd1);
        // R9 clear only the alarm flag
        wr(3'd1, 32'h2);
        expect_reg(3'd1, 32'h0, 32'h2, "R9");
        expect_reg(3'd1, 32'h1, 32'h1, "R9");
        // R10 wrap
        wr(3'd0, 32'hF);
        wr(3'd3, 32'hFFFF_FFFD);
        wr(3'd0, 32'hE);
        run(25);
        expect_reg(3'd1, 32'h4, 32'h4, "R10");
        chk(irq_ovf == 1'b1, "R10", 32'(irq_ovf), 32'd1);
        // R6 source codes
        wr(3'd0, 32'h1E);
        run(120);
        wr(3'd0, 32'h2F);
        wr(3'd2, 32'd1);
        wr(3'd0, 32'h2E);
        run(1500);
        wr(3'd0, 32'h3E);
        rd(3'd3, a);
        run(200);
        rd(3'd3, b);
        chk(a == b, "R6", b, a);
        // R7 calibration with sparser strobes
        ext_every = 2;
        wr(3'd0, 32'h0E);
        run(400);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule